// File: doc/BRIEF.md
# PCIe Root Port Interrupt Aggregator

This block collects the event signals of a PCIe root port bridge and turns them into one interrupt line for the host. Each event source is a one-cycle pulse on its own input bit. The pulse sets a sticky bit in an event status word. Software clears that bit by writing a one to it. An enable word decides which latched events may raise the host interrupt.

The four legacy INTx lines form a second level below the event word. Software sees the live line levels and has a separate enable field for them. Whenever any enabled line is active, one fixed bit of the event word follows it as a level. That bit is not sticky.

A third, smaller status/enable pair handles miscellaneous sources, where only a local-interrupt bit is implemented. The block also reports the link-up level, holds a bridge-enable control bit, and provides a simple 32-bit register port with a single-cycle write strobe and a combinational read.

Top module: `pcie_rp_irq_agg`

## Requirements
- R1: After reset, every register reads zero (link-up bit aside, which follows its input), `bridge_en` is 0 and `host_irq` is 0.
- R2: A one-cycle pulse on `evt_src[i]` sets bit i of the event status word (offset 0xE10) from the next clock edge, and the bit stays set until cleared. Bit i must be one of the implemented positions: 0, 3, 4, 8, 9, 10, 11, 12, 15, 17 and 20 through 28.
- R3: Writing to 0xE10 clears each status bit written with 1 and leaves each bit written with 0 unchanged.
- R4: When a pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The event enable word (offset 0xE14, 1 = pass) gates the status word. `host_irq` is high exactly when some status bit and its enable bit are both 1, or when some miscellaneous status bit and its enable bit are both 1.
- R6: Status and enable bits with no assigned event never set and always read 0.
- R7: Offset 0xE38 shows the live levels of INTA..INTD in bits 16..19. Offset 0xE3C holds their enables (1 = enabled) in the same bits.
- R8: Event bit 16 reads 1 exactly while some INTx line is both active and enabled. It is a level, and writing 1 to it has no effect.
- R9: Offset 0xE1C bit 11 shows `link_up`. Offset 0xE20 bit 0 is a read/write bridge-enable bit that drives `bridge_en`. All other bits of these two offsets read 0.
- R10: Offset 0x340 bit 1 is a sticky, write-one-to-clear status bit set by `misc_src[1]`. Offset 0x348 bit 1 is its enable. All other bits of both offsets read 0.
- R11: A read from any offset not listed above returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data at `bus_addr` |
| evt_src | input | 32 | Event pulses, one bit per event position |
| intx_lines | input | 4 | Level INTA..INTD lines |
| misc_src | input | 32 | Miscellaneous event pulses |
| link_up | input | 1 | Link-up level |
| bridge_en | output | 1 | Bridge enable control |
| host_irq | output | 1 | Combined interrupt to the host |

## Verification
The bench builds the block with its default parameters: a 32-bit word, four INTx lines at bit 16, and the implemented-event map listed above. This small configuration lets the bench sweep every one of the 32 event positions through latch, zero-write hold and one-write clear. It also enables each position alone to check the interrupt gate, and covers all 256 pairs of INTx line levels and INTx enables against the chained bit and the host output. Finally it reads every word offset in the 4 KiB window to confirm that unmapped offsets return zero, and it drives the same-cycle set/clear collision directly.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int unsigned ADDR_W = 12;

   localparam logic [ADDR_W-1:0] OFF_EVT_STAT  = 12'hE10;
   localparam logic [ADDR_W-1:0] OFF_EVT_EN    = 12'hE14;
   localparam logic [ADDR_W-1:0] OFF_PHY_STAT  = 12'hE1C;
   localparam logic [ADDR_W-1:0] OFF_PORT_CTL  = 12'hE20;
   localparam logic [ADDR_W-1:0] OFF_INTX_STAT = 12'hE38;
   localparam logic [ADDR_W-1:0] OFF_INTX_EN   = 12'hE3C;
   localparam logic [ADDR_W-1:0] OFF_AUX_STAT  = 12'h340;
   localparam logic [ADDR_W-1:0] OFF_AUX_EN    = 12'h348;

   localparam int unsigned LINK_UP_BIT  = 11;
   localparam int unsigned BRIDGE_BIT   = 0;
   localparam int unsigned EVT_INTX_BIT = 16;
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
   parameter int unsigned     W     = 32,
   parameter logic [W-1:0]    VALID = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  set_i,
   input  logic [W-1:0]  clr_i,
   output logic [W-1:0]  q_o
);
   localparam logic [W-1:0] LIVE = VALID;

   for (genvar gi = 0; gi < W; gi++) begin : g_bit
      if (LIVE[gi]) begin : g_flop
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_i[gi])  bit_q <= 1'b1;
            else if (clr_i[gi])  bit_q <= 1'b0;
         end
         assign q_o[gi] = bit_q;
      end else begin : g_tie
         assign q_o[gi] = 1'b0;
      end
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i & LIVE) != '0) |=> ((q_o & $past(set_i & LIVE)) == $past(set_i & LIVE))); // R4
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0)); // R3
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && clr_i == '0) |=> $stable(q_o)); // R2
endmodule

// File: rtl/irq_intx_gate.sv
module irq_intx_gate #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] lines_i,
   input  logic [N-1:0] en_i,
   output logic         any_o
);
   logic [N-1:0] pass;
   for (genvar gi = 0; gi < N; gi++) begin : g_line
      assign pass[gi] = lines_i[gi] & en_i[gi];
   end
   assign any_o = |pass;

   always_comb begin
      if (lines_i == '0) AST_INTX_IDLE: assert (!any_o); // R8
   end
endmodule

// File: rtl/pcie_rp_irq_agg.sv
module pcie_rp_irq_agg
   import irq_agg_pkg::*;
#(
   parameter int unsigned     DW         = 32,
   parameter int unsigned     NUM_INTX   = 4,
   parameter int unsigned     INTX_LSB   = 16,
   parameter logic [DW-1:0]   EVT_VALID  = 32'h1FF3_9F19,
   parameter logic [DW-1:0]   MISC_VALID = 32'h0000_0002
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   input  logic [DW-1:0]       evt_src,
   input  logic [NUM_INTX-1:0] intx_lines,
   input  logic [DW-1:0]       misc_src,
   input  logic                link_up,
   output logic                bridge_en,
   output logic                host_irq
);
   localparam logic [DW-1:0] INTX_BIT_M = DW'(1) << EVT_INTX_BIT;
   localparam logic [DW-1:0] STICKY_M   = EVT_VALID & ~INTX_BIT_M;

   if (INTX_LSB + NUM_INTX > DW) begin : g_bad_intx
      $error("INTx field exceeds the data width");
   end
   if (EVT_INTX_BIT >= DW || LINK_UP_BIT >= DW) begin : g_bad_bits
      $error("fixed bit position outside the data width");
   end

   logic sel_evt_stat, sel_evt_en, sel_ctl, sel_intx_en, sel_aux_stat, sel_aux_en;
   assign sel_evt_stat = bus_we && (bus_addr == OFF_EVT_STAT);
   assign sel_evt_en   = bus_we && (bus_addr == OFF_EVT_EN);
   assign sel_ctl      = bus_we && (bus_addr == OFF_PORT_CTL);
   assign sel_intx_en  = bus_we && (bus_addr == OFF_INTX_EN);
   assign sel_aux_stat = bus_we && (bus_addr == OFF_AUX_STAT);
   assign sel_aux_en   = bus_we && (bus_addr == OFF_AUX_EN);

   logic [DW-1:0] evt_q, aux_q;

   irq_w1c_bank #(.W(DW), .VALID(STICKY_M)) u_evt_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_src),
      .clr_i (sel_evt_stat ? bus_wdata : '0),
      .q_o   (evt_q)
   );

   irq_w1c_bank #(.W(DW), .VALID(MISC_VALID)) u_aux_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (misc_src),
      .clr_i (sel_aux_stat ? bus_wdata : '0),
      .q_o   (aux_q)
   );

   logic [DW-1:0]       evt_en_q, aux_en_q;
   logic [NUM_INTX-1:0] intx_en_q;
   logic                bridge_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_en_q  <= '0;
         aux_en_q  <= '0;
         intx_en_q <= '0;
         bridge_q  <= 1'b0;
      end else begin
         if (sel_evt_en)  evt_en_q  <= bus_wdata & EVT_VALID;
         if (sel_aux_en)  aux_en_q  <= bus_wdata & MISC_VALID;
         if (sel_intx_en) intx_en_q <= bus_wdata[INTX_LSB +: NUM_INTX];
         if (sel_ctl)     bridge_q  <= bus_wdata[BRIDGE_BIT];
      end
   end

   logic intx_any;
   irq_intx_gate #(.N(NUM_INTX)) u_intx (
      .lines_i (intx_lines),
      .en_i    (intx_en_q),
      .any_o   (intx_any)
   );

   logic [DW-1:0] evt_view;
   assign evt_view  = evt_q | (intx_any ? INTX_BIT_M : '0);
   assign host_irq  = (|(evt_view & evt_en_q)) | (|(aux_q & aux_en_q));
   assign bridge_en = bridge_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFF_EVT_STAT:  bus_rdata = evt_view;
         OFF_EVT_EN:    bus_rdata = evt_en_q;
         OFF_PHY_STAT:  bus_rdata[LINK_UP_BIT] = link_up;
         OFF_PORT_CTL:  bus_rdata[BRIDGE_BIT] = bridge_q;
         OFF_INTX_STAT: bus_rdata[INTX_LSB +: NUM_INTX] = intx_lines;
         OFF_INTX_EN:   bus_rdata[INTX_LSB +: NUM_INTX] = intx_en_q;
         OFF_AUX_STAT:  bus_rdata = aux_q;
         OFF_AUX_EN:    bus_rdata = aux_en_q;
         default:       bus_rdata = '0;
      endcase
   end

   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_en_q == '0 && aux_en_q == '0) |-> !host_irq); // R5
   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_evt_en |=> $stable(evt_en_q)); // R5
   AST_BRIDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ctl |=> $stable(bridge_en)); // R9
   AST_UNUSED_EN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sel_evt_en |=> ((evt_en_q & ~EVT_VALID) == '0)); // R6
endmodule

// File: tb/tb_pcie_rp_irq_agg.sv
`timescale 1ns/1ps
module tb_pcie_rp_irq_agg;
   localparam logic [31:0] EV  = 32'h1FF3_9F19;
   localparam logic [31:0] STK = EV & ~32'h0001_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] evt_src = '0;
   logic [3:0]  intx_lines = '0;
   logic [31:0] misc_src = '0;
   logic        link_up = 1'b0;
   logic        bridge_en, host_irq;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   always #2.5 clk = ~clk;

   pcie_rp_irq_agg dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_src(evt_src),
      .intx_lines(intx_lines), .misc_src(misc_src), .link_up(link_up),
      .bridge_en(bridge_en), .host_irq(host_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [31:0] ev, input logic [31:0] ms);
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_wdata = d; evt_src = ev; misc_src = ms;
      @(negedge clk);
      bus_we = 1'b0; evt_src = '0; misc_src = '0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, '0, '0);
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      begin
         logic [11:0] offs [8] = '{12'hE10, 12'hE14, 12'hE1C, 12'hE20,
                                   12'hE38, 12'hE3C, 12'h340, 12'h348};
         for (int k = 0; k < 8; k++) begin
            rd(offs[k], r); chk("R1 reset reg", r, 32'h0);
         end
      end
      chk("R1 host_irq", {31'b0, host_irq}, 32'h0);
      chk("R1 bridge_en", {31'b0, bridge_en}, 32'h0);

      // R2 R3 R6: latch, zero-write hold, one-write clear on every position
      for (int i = 0; i < 32; i++) begin
         logic [31:0] b;
         b = 32'h1 << i;
         cyc(1'b0, 12'h0, '0, b, '0);
         rd(12'hE10, r); chk("R2/R6 latch", r, STK & b);
         wr(12'hE10, ~b);
         rd(12'hE10, r); chk("R3 zero-write hold", r, STK & b);
         wr(12'hE10, b);
         rd(12'hE10, r); chk("R3 one-write clear", r, 32'h0);
      end

      // R4: set wins over a same-cycle clear
      cyc(1'b1, 12'hE10, 32'h0000_0200, 32'h0000_0200, '0);
      rd(12'hE10, r); chk("R4 set wins", r, 32'h0000_0200);
      wr(12'hE10, 32'hFFFF_FFFF);
      rd(12'hE10, r); chk("R4 cleared after", r, 32'h0);

      // R5 R6: enable gating per position
      for (int i = 0; i < 32; i++) begin
         logic [31:0] b;
         b = 32'h1 << i;
         cyc(1'b0, 12'h0, '0, b, '0);
         chk("R5 blocked when disabled", {31'b0, host_irq}, 32'h0);
         wr(12'hE14, b);
         rd(12'hE14, r); chk("R6 enable readback", r, EV & b);
         chk("R5 irq passes", {31'b0, host_irq}, {31'b0, |(STK & b)});
         wr(12'hE10, b);
         chk("R5 irq after clear", {31'b0, host_irq}, 32'h0);
         wr(12'hE14, 32'h0);
      end

      // R7 R8: all INTx line and enable combinations
      wr(12'hE14, 32'h0001_0000);
      for (int en = 0; en < 16; en++) begin
         wr(12'hE3C, 32'(en) << 16);
         rd(12'hE3C, r); chk("R7 intx enable readback", r, 32'(en) << 16);
         for (int ln = 0; ln < 16; ln++) begin
            logic hit;
            intx_lines = 4'(ln);
            hit = ((ln & en) != 0);
            rd(12'hE38, r); chk("R7 intx line view", r, 32'(ln) << 16);
            rd(12'hE10, r); chk("R8 chained bit", r, hit ? 32'h0001_0000 : 32'h0);
            chk("R8 chained irq", {31'b0, host_irq}, {31'b0, hit});
         end
      end
      intx_lines = 4'b0100;
      wr(12'hE3C, 32'h000F_0000);
      wr(12'hE10, 32'h0001_0000);
      rd(12'hE10, r); chk("R8 write-one no effect", r, 32'h0001_0000);
      intx_lines = 4'b0000;
      rd(12'hE10, r); chk("R8 level follows line", r, 32'h0);
      wr(12'hE14, 32'h0);

      // R9: link-up status and bridge enable
      link_up = 1'b1;
      rd(12'hE1C, r); chk("R9 link up", r, 32'h0000_0800);
      link_up = 1'b0;
      rd(12'hE1C, r); chk("R9 link down", r, 32'h0);
      wr(12'hE20, 32'hFFFF_FFFF);
      rd(12'hE20, r); chk("R9 bridge readback", r, 32'h1);
      chk("R9 bridge_en port", {31'b0, bridge_en}, 32'h1);

      // R10: miscellaneous status and enable
      cyc(1'b0, 12'h0, '0, '0, 32'hFFFF_FFFF);
      rd(12'h340, r); chk("R10 misc latch", r, 32'h2);
      chk("R10 misc blocked", {31'b0, host_irq}, 32'h0);
      wr(12'h348, 32'hFFFF_FFFF);
      rd(12'h348, r); chk("R10 misc enable", r, 32'h2);
      chk("R10 misc irq", {31'b0, host_irq}, 32'h1);
      wr(12'h340, 32'h0);
      rd(12'h340, r); chk("R10 misc zero-write hold", r, 32'h2);
      wr(12'h340, 32'h2);
      rd(12'h340, r); chk("R10 misc clear", r, 32'h0);
      chk("R10 misc irq cleared", {31'b0, host_irq}, 32'h0);

      // R11: every unmapped word offset reads zero
      wr(12'hE14, 32'hFFFF_FFFF);
      cyc(1'b0, 12'h0, '0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      for (int a = 0; a < 4096; a += 4) begin
         logic [11:0] aa;
         aa = 12'(a);
         if (aa != 12'hE10 && aa != 12'hE14 && aa != 12'hE1C && aa != 12'hE20 &&
             aa != 12'hE38 && aa != 12'hE3C && aa != 12'h340 && aa != 12'h348) begin
            rd(aa, r); chk("R11 unmapped read", r, 32'h0);
         end
      end
      rd(12'hE10, r); chk("R2 full latch map", r, STK);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule